// File: doc/BRIEF.md
# Speech PWM Output Stage with Drive Selection

This block turns 7-bit unsigned speech samples into a pulse-width-modulated waveform on a pair of complementary pins. It also produces a 5-bit vector of enables for parallel output drivers, which sets the output volume. Software reaches the block through one write port with three targets. A voice control word holds a master bit. A command word holds the PWM enable and a 3-bit drive code. A sample word holds the next audio value. A low-power request from the clock controller switches voice output off.

The control path is a three-state machine. The states are `ST_OFF` (master bit clear), `ST_ARMED` (master bit set, PWM not enabled) and `ST_RUN` (PWM enabled and counting). The transitions are:
- Master-on write: `ST_OFF` to `ST_ARMED`.
- Master-off write, or low-power request: `ST_ARMED` or `ST_RUN` to `ST_OFF`, with the command cleared.
- Command write with enable 1: `ST_ARMED` to `ST_RUN`. In `ST_RUN` it stays in `ST_RUN` and updates the code.
- Command write with enable 0: `ST_ARMED` or `ST_RUN` to `ST_ARMED`.

Each PWM frame lasts 128 clock cycles. A new sample is taken only when a frame begins.

Top module: `speech_pwm`

## Requirements
- R1: While reset is held, and right after it, `pwm_p`, `pwm_n` and `drv_en` are all 0 and the master bit is clear.
- R2: While running, each frame is 128 cycles long. `pwm_p` is high for the first S cycles of the frame and low for the rest, where S is sample bits [6:0]. S=0 gives a permanently low output.
- R3: The sample is latched when a frame starts. This is the enabling command write, or the end of the previous frame. A sample written in the middle of a frame takes effect from the next frame.
- R4: While running, `pwm_n` is the inverse of `pwm_p` in every cycle.
- R5: The drive code is command bits [6:4]. Bit 6 drives `drv_en[4:3]`, bit 5 drives `drv_en[2:1]` and bit 4 drives `drv_en[0]`. Codes 0 to 7 therefore give 0,1,2,3,2,3,4,5 active drivers.
- R6: Whenever the PWM is not running (enable bit 0 or master bit 0), `pwm_p`, `pwm_n` and `drv_en` are all 0.
- R7: A command write (select 1, enable bit 0) made while the master bit is clear has no effect.
- R8: Writing 0 to the master bit (select 0, bit 0) clears the enable and the drive code. Setting the master bit again leaves them clear.
- R9: `lowpwr_req` clears the master bit, the enable and the drive code. It wins over a register write in the same cycle.
- R10: The frame counter runs only while enabled. Every enable starts a fresh frame at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 voice control, 1 command, 2 sample, 3 none |
| wr_data | input | 8 | Write data |
| lowpwr_req | input | 1 | One-cycle pulse on sleep or idle entry |
| pwm_p | output | 1 | PWM output |
| pwm_n | output | 1 | Complementary PWM output |
| drv_en | output | 5 | Parallel output driver enables |

## Verification
A low-power request can arrive in the same cycle as a command write that would enable the PWM. The bench drives both in one cycle. It judges the result by the quiet outputs, and again after the master bit is re-armed, when the drivers must stay off. A sample write can also coincide with a running frame. The bench writes a new value mid-frame and checks that the rest of that frame still follows the old duty, and that the new duty appears exactly from the next 128-cycle boundary.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } spwm_state_e;

    typedef enum logic [1:0] {
        SEL_VOICE  = 2'd0,
        SEL_CMD    = 2'd1,
        SEL_SAMPLE = 2'd2,
        SEL_NONE   = 2'd3
    } spwm_sel_e;
endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
    import spwm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SAMPLE_W = 7,
    parameter int CODE_W   = 3,
    parameter int CODE_LSB = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                lowpwr_req,
    output logic                run_o,
    output logic                start_o,
    output logic [CODE_W-1:0]   code_o,
    output logic [SAMPLE_W-1:0] sample_o
);
    spwm_state_e         state_q, state_d;
    logic [CODE_W-1:0]   code_q, code_d;
    logic [SAMPLE_W-1:0] sample_q;
    logic                voice_on, voice_off, cmd_wr, unused_ok;

    assign voice_on  = wr_en && (wr_sel == SEL_VOICE) &&  wr_data[0];
    assign voice_off = wr_en && (wr_sel == SEL_VOICE) && !wr_data[0];
    assign cmd_wr    = wr_en && (wr_sel == SEL_CMD);
    assign unused_ok = ^wr_data;

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_OFF: begin
                code_d = '0;
                if (!lowpwr_req && voice_on) state_d = ST_ARMED;
            end
            ST_ARMED, ST_RUN: begin
                if (lowpwr_req || voice_off) begin
                    state_d = ST_OFF;
                    code_d  = '0;
                end else if (cmd_wr) begin
                    code_d  = wr_data[CODE_LSB +: CODE_W];
                    state_d = wr_data[0] ? ST_RUN : ST_ARMED;
                end
            end
            default: begin
                state_d = ST_OFF;
                code_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sample_q <= '0;
        else if (wr_en && (wr_sel == SEL_SAMPLE))
            sample_q <= wr_data[SAMPLE_W-1:0];
    end

    always_comb begin
        run_o    = (state_q == ST_RUN);
        start_o  = (state_d == ST_RUN) && (state_q != ST_RUN);
        code_o   = code_q;
        sample_o = sample_q;
    end

    // R9: low-power entry always ends in the off state
    a_r9_lowpwr_off: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_req |=> (state_q == ST_OFF));
    // R8: no command survives while the master bit is clear
    a_r8_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (code_q == '0));
    // R7: command writes without the master bit leave everything off
    a_r7_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_OFF) && cmd_wr) |=> ((state_q == ST_OFF) && (code_q == '0)));
endmodule

// File: rtl/spwm_frame.sv
module spwm_frame #(
    parameter int SAMPLE_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                start,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                pwm_hi
);
    localparam logic [SAMPLE_W-1:0] FRAME_LAST = '1;

    logic [SAMPLE_W-1:0] cnt_q, lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            lat_q <= sample;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == FRAME_LAST) lat_q <= sample;
        end else begin
            cnt_q <= '0;
        end
    end

    assign pwm_hi = run && (cnt_q < lat_q);

    // R3: the latched duty changes only at a frame start
    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(lat_q));
    // R10: the counter advances by one each cycle while running
    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run) |-> (cnt_q == SAMPLE_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/spwm_drv.sv
module spwm_drv #(
    parameter int CODE_W = 3,
    localparam int DRV_N = 2 * CODE_W - 1
) (
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic [DRV_N-1:0]  drv
);
    generate
        for (genvar j = 0; j < CODE_W; j++) begin : g_bit
            if (j == 0) begin : g_single
                assign drv[0] = en && code[0];
            end else begin : g_double
                assign drv[2*j-1 +: 2] = {2{en && code[j]}};
            end
        end
    endgenerate
endmodule

// File: rtl/speech_pwm.sv
module speech_pwm #(
    parameter int DATA_W   = 8,
    parameter int SAMPLE_W = 7,
    parameter int CODE_W   = 3,
    parameter int CODE_LSB = 4,
    localparam int DRV_N   = 2 * CODE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lowpwr_req,
    output logic              pwm_p,
    output logic              pwm_n,
    output logic [DRV_N-1:0]  drv_en
);
    logic                run, start, hi;
    logic [CODE_W-1:0]   code;
    logic [SAMPLE_W-1:0] sample;

    spwm_ctrl #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lowpwr_req(lowpwr_req), .run_o(run), .start_o(start), .code_o(code), .sample_o(sample)
    );

    spwm_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start), .sample(sample), .pwm_hi(hi)
    );

    spwm_drv #(.CODE_W(CODE_W)) u_drv (
        .en(run), .code(code), .drv(drv_en)
    );

    assign pwm_p = hi;
    assign pwm_n = run && !hi;

    // R4: complementary pair while running
    a_r4_complement: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pwm_n != pwm_p));
    // R6: everything quiet when not running
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm_p && !pwm_n && (drv_en == '0)));
endmodule

// File: tb/test_speech_pwm.sv
module test_speech_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       lowpwr_req = 1'b0;
    logic       pwm_p, pwm_n;
    logic [4:0] drv_en;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    speech_pwm i_speech_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lowpwr_req(lowpwr_req), .pwm_p(pwm_p), .pwm_n(pwm_n), .drv_en(drv_en)
    );

    // {sample[6:0], code[2:0]}
    localparam logic [9:0] VEC [8] = '{
        {7'd0, 3'd1}, {7'd1, 3'd2}, {7'd64, 3'd3}, {7'd127, 3'd4},
        {7'd5, 3'd5}, {7'd100, 3'd6}, {7'd33, 3'd7}, {7'd90, 3'd0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // walks n cycles starting at frame cycle first; returns cycles that broke the pattern
    task automatic walk(input int first, input int n, input int duty, output int highs, output int bad);
        highs = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_p) highs++;
            if ((pwm_p !== ((first + i) < duty)) || (pwm_n !== ~pwm_p)) bad++;
            @(negedge clk);
        end
    endtask

    function automatic logic [4:0] exp_drv(input logic [2:0] c);
        return {c[2], c[2], c[1], c[1], c[0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int highs, bad;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({pwm_p, pwm_n, drv_en} == 7'd0, "R1 outputs in reset", {pwm_p, pwm_n, drv_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({pwm_p, pwm_n, drv_en} == 7'd0, "R1 outputs after reset", {pwm_p, pwm_n, drv_en}, 0);

        // R7: command while master clear is ignored
        wr(2'd2, 8'd50);
        wr(2'd1, 8'h71);
        check({pwm_p, pwm_n, drv_en} == 7'd0, "R7 cmd ignored", {pwm_p, pwm_n, drv_en}, 0);
        wr(2'd0, 8'h01);
        check(drv_en == 5'd0 && !pwm_p, "R7 nothing stored", drv_en, 0);

        // R2 R4 R5 R10: vector table
        foreach (VEC[v]) begin
            wr(2'd1, 8'h00);
            check({pwm_p, pwm_n, drv_en} == 7'd0, "R6 enable clear", {pwm_p, pwm_n, drv_en}, 0);
            wr(2'd2, {1'b0, VEC[v][9:3]});
            wr(2'd1, {1'b0, VEC[v][2:0], 4'h1});
            check(drv_en == exp_drv(VEC[v][2:0]), "R5 driver map", drv_en, exp_drv(VEC[v][2:0]));
            walk(0, 128, VEC[v][9:3], highs, bad);
            check(bad == 0 && highs == VEC[v][9:3], "R2 R4 R10 frame", highs, VEC[v][9:3]);
        end

        // R3: mid-frame sample write
        wr(2'd1, 8'h00);
        wr(2'd2, 8'd10);
        wr(2'd1, 8'h11);
        repeat (40) @(negedge clk);
        wr(2'd2, 8'd100);
        walk(41, 87, 10, highs, bad);
        check(bad == 0 && highs == 0, "R3 old sample kept", highs, 0);
        walk(0, 128, 100, highs, bad);
        check(bad == 0 && highs == 100, "R3 new sample next frame", highs, 100);

        // R8: master clear wipes command
        wr(2'd1, 8'h71);
        check(drv_en == 5'h1F, "R8 running", drv_en, 31);
        wr(2'd0, 8'h00);
        check({pwm_p, pwm_n, drv_en} == 7'd0, "R8 master off", {pwm_p, pwm_n, drv_en}, 0);
        wr(2'd0, 8'h01);
        repeat (3) @(negedge clk);
        check({pwm_p, pwm_n, drv_en} == 7'd0, "R8 rearm stays clear", {pwm_p, pwm_n, drv_en}, 0);

        // R9: low-power with a simultaneous enabling command write
        wr(2'd1, 8'h51);
        check(drv_en == 5'b11001, "R9 running", drv_en, 25);
        lowpwr_req = 1'b1;
        wr(2'd1, 8'h61);
        lowpwr_req = 1'b0;
        check({pwm_p, pwm_n, drv_en} == 7'd0, "R9 lowpwr wins", {pwm_p, pwm_n, drv_en}, 0);
        wr(2'd0, 8'h01);
        check(drv_en == 5'd0 && !pwm_p, "R9 cmd cleared", drv_en, 0);
        wr(2'd1, 8'h21);
        check(drv_en == 5'b00110, "R9 usable after rearm", drv_en, 6);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule